// File: doc/BRIEF.md
# CAN Receive Queue with Masked Identifier Acceptance

This block sits behind a CAN receive engine and keeps only the frames the host cares about. The engine hands over each frame in pieces: a header strobe with the 29-bit identifier, the remote-request and extended-format flags and the byte count, then single byte writes addressed by lane index, and finally a completion strobe. When the frame completes, its header is compared against a bank of twenty value/mask filter pairs, each of which can be switched off. A frame that no enabled filter accepts is thrown away. An accepted frame goes into a three-entry queue together with the number of the filter that accepted it.

The oldest stored frame is always presented on the output ports. These carry its identifier, flags, length, its eight data bytes as two 32-bit words, and the accepting filter number. A pop strobe removes it and is acknowledged one cycle later. A policy input chooses what happens when a frame is accepted while the queue is full: either the most recently stored entry is replaced, or the new frame is dropped. In both cases a sticky overrun flag is raised, and the next pop clears it.

Top module: `can_rx_filter_fifo`

## Requirements
- R1: After a synchronous active-low reset the queue holds nothing: `q_count` is 0, `q_empty` is 1, `q_full`, `q_overrun` and `pop_ack` are 0, and every head output is zero.
- R2: The match key is the 31-bit word {rtr, ext, id}, with bit 30 = remote flag, bit 29 = extended flag, bits 28:18 = standard identifier and bits 17:0 = extension bits. Filter i (value and mask at bits i*31 and up of the flat buses) accepts when its enable bit is 1 and every key bit whose mask bit is 1 equals the value bit. A completed frame that no enabled filter accepts is dropped and leaves the queue unchanged.
- R3: When several enabled filters accept a frame, the stored filter number (`head_hit`) is the lowest of them.
- R4: A header strobe captures the identifier, both flags and the length, and clears all eight byte lanes to zero.
- R5: A byte write with index k in 0..7 stores the byte in lane k. The low output word holds lanes 0..3 and the high word lanes 4..7, lane 0 in bits 7:0 of the low word and lane 4 in bits 7:0 of the high word. Writes with index 8..15 are ignored.
- R6: Lanes at positions equal to or above the captured length are stored and presented as zero.
- R7: Accepted frames leave in arrival order. `q_count` follows the number held, `q_full` is 1 at three entries, and the head outputs are zero while the queue is empty.
- R8: A pop while non-empty removes the head, and `pop_ack` is 1 for the single cycle after it. A pop while empty changes nothing and gives no acknowledge.
- R9: With `ovr_replace` = 1, an accepted frame arriving while the queue is full and no pop is accepted overwrites the most recently stored entry. `q_overrun` goes to 1 and the count stays at three.
- R10: With `ovr_replace` = 0, such a frame is discarded and the stored entries are kept. `q_overrun` goes to 1.
- R11: `q_overrun` clears on the next accepted pop. A completion and an accepted pop in the same cycle on a full queue store the new frame without raising overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_strobe | input | 1 | Capture header for a new frame |
| hdr_id | input | 29 | Identifier, standard bits 28:18, extension bits 17:0 |
| hdr_rtr | input | 1 | Remote-request flag |
| hdr_ext | input | 1 | Extended-format flag |
| hdr_len | input | 4 | Byte count, 0 to 8 |
| byte_wr | input | 1 | Write one data byte |
| byte_idx | input | 4 | Lane index of the byte |
| byte_val | input | 8 | Byte value |
| frame_done | input | 1 | Frame complete, run acceptance |
| ovr_replace | input | 1 | Full-queue policy: 1 replace newest, 0 discard |
| flt_enable | input | 20 | Per-filter enable |
| flt_value | input | 620 | Filter values, 31 bits each |
| flt_mask | input | 620 | Filter masks, 31 bits each, 1 = compared |
| pop | input | 1 | Remove head entry |
| q_count | output | 4 | Entries held |
| q_full | output | 1 | Queue full |
| q_empty | output | 1 | Queue empty |
| q_overrun | output | 1 | Sticky overrun flag |
| head_lo | output | 32 | Head data lanes 0..3 |
| head_hi | output | 32 | Head data lanes 4..7 |
| head_id | output | 29 | Head identifier |
| head_len | output | 4 | Head length |
| head_rtr | output | 1 | Head remote flag |
| head_ext | output | 1 | Head extended flag |
| head_hit | output | 5 | Number of the accepting filter |
| pop_ack | output | 1 | Pop acknowledge, one cycle after an accepted pop |

## Verification
The bench aims at overlapping filters, so a priority encoder that picks the highest match would record the wrong filter number, and a disabled filter that still votes would let a frame through that should be dropped. It writes more lanes than the length allows and stray indices above seven. A design that skipped masking or decoded only three index bits would show non-zero bytes there, and one that did not clear lanes on a new header would leak the previous frame's data. It fills the queue and drives the full-queue path under both policies, plus the case of a completion in the same cycle as a pop. A design that confused the oldest with the newest slot, flagged overrun while a pop freed room, or left overrun set after a pop would break the ordered scoreboard comparison or the status check.

// File: rtl/can_rxf_pkg.sv
// Shared widths and the frame record used by the receive queue.
// Assumes the classic CAN header: 29-bit identifier, two flags, up to 8 bytes.
package can_rxf_pkg;
    localparam int ID_W      = 29;
    localparam int LEN_W     = 4;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = MAX_BYTES * BYTE_W;
    localparam int KEY_W     = ID_W + 2;
    localparam int WORD_W    = DATA_W / 2;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              rtr;
        logic              ext;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/can_rxf_assembler.sv
// Builds one frame from a header strobe and indexed byte writes.
// The header strobe clears every lane; lanes at or above the length are
// presented as zero. Indices outside 0..MAX_BYTES-1 are ignored.
// Assumes the header strobe and byte writes do not share a cycle
// (if they do, the header wins and the byte is lost).
module can_rxf_assembler
    import can_rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_strobe,
    input  logic [ID_W-1:0]   hdr_id,
    input  logic              hdr_rtr,
    input  logic              hdr_ext,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic              byte_wr,
    input  logic [LEN_W-1:0]  byte_idx,
    input  logic [BYTE_W-1:0] byte_val,
    output frame_t            frame_o,
    output logic [KEY_W-1:0]  key_o
);
    logic [ID_W-1:0]   id_q;
    logic              rtr_q;
    logic              ext_q;
    logic [LEN_W-1:0]  len_q;
    logic [BYTE_W-1:0] lane_q [MAX_BYTES];
    logic [DATA_W-1:0] data_masked;

    // Header registers: capture on strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            rtr_q <= 1'b0;
            ext_q <= 1'b0;
            len_q <= '0;
        end else if (hdr_strobe) begin
            id_q  <= hdr_id;
            rtr_q <= hdr_rtr;
            ext_q <= hdr_ext;
            len_q <= hdr_len;
        end
    end

    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
        // Lane k: cleared by reset or header, loaded by a matching byte write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[k] <= '0;
            end else if (hdr_strobe) begin
                lane_q[k] <= '0;
            end else if (byte_wr && (byte_idx == LEN_W'(k))) begin
                lane_q[k] <= byte_val;
            end
        end

        assign data_masked[k*BYTE_W +: BYTE_W] = (LEN_W'(k) < len_q) ? lane_q[k] : '0;

        // R4
        lane_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hdr_strobe |=> (lane_q[k] == '0));
    end

    // Output record and match key from the captured header.
    always_comb begin
        frame_o.id   = id_q;
        frame_o.rtr  = rtr_q;
        frame_o.ext  = ext_q;
        frame_o.len  = len_q;
        frame_o.data = data_masked;
        key_o        = {rtr_q, ext_q, id_q};
    end
endmodule

// File: rtl/can_rxf_filter_bank.sv
// Compares a 31-bit key against NUM_FLT value/mask pairs. A mask bit of 1
// means the bit is compared. The lowest-numbered enabled match wins.
// Purely combinational; assumes the key is stable from a register.
module can_rxf_filter_bank
    import can_rxf_pkg::*;
#(
    parameter int NUM_FLT = 20,
    parameter int HIT_W   = 5
) (
    input  logic [KEY_W-1:0]         key_i,
    input  logic [NUM_FLT-1:0]       enable_i,
    input  logic [NUM_FLT*KEY_W-1:0] values_i,
    input  logic [NUM_FLT*KEY_W-1:0] masks_i,
    output logic                     hit_any_o,
    output logic [HIT_W-1:0]         hit_idx_o
);
    logic [NUM_FLT-1:0] match;

    for (genvar i = 0; i < NUM_FLT; i++) begin : g_flt
        assign match[i] = enable_i[i] &&
            (((key_i ^ values_i[i*KEY_W +: KEY_W]) & masks_i[i*KEY_W +: KEY_W]) == '0);
    end

    // Priority pick: scan downwards so the lowest index is assigned last.
    always_comb begin
        hit_idx_o = '0;
        for (int i = NUM_FLT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx_o = HIT_W'(i);
            end
        end
        hit_any_o = |match;
    end
endmodule

// File: rtl/can_rxf_queue.sv
// Circular frame store of DEPTH entries with a sticky overrun flag.
// On a push into a full queue with no pop, replace_en picks overwrite of
// the newest entry (1) or discard (0). A same-cycle pop frees a slot first.
// Storage cells carry no reset; head outputs read zero while empty.
module can_rxf_queue
    import can_rxf_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int HIT_W = 5,
    parameter int OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  frame_t           push_frame,
    input  logic [HIT_W-1:0] push_hit,
    input  logic             pop,
    input  logic             replace_en,
    output frame_t           head_frame,
    output logic [HIT_W-1:0] head_hit,
    output logic [OCC_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             overrun,
    output logic             pop_ack
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] FULL_CNT = OCC_W'(DEPTH);

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST_PTR : p - 1'b1;
    endfunction

    frame_t           mem_q [DEPTH];
    logic [HIT_W-1:0] hit_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, newest;
    logic [OCC_W-1:0] count_q;
    logic             ovr_q, ack_q;
    logic             pop_go, room, push_go, ovr_evt, ovr_wr;

    assign empty   = (count_q == '0);
    assign full    = (count_q == FULL_CNT);
    assign pop_go  = pop && !empty;
    assign room    = !full || pop_go;
    assign push_go = push && room;
    assign ovr_evt = push && !room;
    assign ovr_wr  = ovr_evt && replace_en;
    assign newest  = ptr_dec(wr_ptr_q);

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Slot s: written by a normal push or by a replacing overrun.
        always_ff @(posedge clk) begin
            if ((push_go && (wr_ptr_q == PTR_W'(s))) || (ovr_wr && (newest == PTR_W'(s)))) begin
                mem_q[s] <= push_frame;
                hit_q[s] <= push_hit;
            end
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_go) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (pop_go)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            count_q <= count_q + OCC_W'(push_go) - OCC_W'(pop_go);
        end
    end

    // Overrun flag set by a blocked push, cleared by an accepted pop; pop acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            if (ovr_evt)     ovr_q <= 1'b1;
            else if (pop_go) ovr_q <= 1'b0;
            ack_q <= pop_go;
        end
    end

    assign head_frame = empty ? '0 : mem_q[rd_ptr_q];
    assign head_hit   = empty ? '0 : hit_q[rd_ptr_q];
    assign count      = count_q;
    assign overrun    = ovr_q;
    assign pop_ack    = ack_q;

    // R7
    occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);

    // R7
    push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count_q == $past(count_q) + 1'b1));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (empty && !ack_q));

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (ovr_q && full));

    // R11
    ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> !ovr_q);
endmodule

// File: rtl/can_rx_filter_fifo.sv
// Receive queue with masked acceptance filters. Assembles a frame from
// header and byte strobes, runs the filter bank on completion, and stores
// accepted frames with the accepting filter number. Synchronous active-low reset.
module can_rx_filter_fifo
    import can_rxf_pkg::*;
#(
    parameter int NUM_FLT = 20,
    parameter int DEPTH   = 3,
    parameter int OCC_W   = 4,
    parameter int HIT_W   = (NUM_FLT > 1) ? $clog2(NUM_FLT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hdr_strobe,
    input  logic [ID_W-1:0]          hdr_id,
    input  logic                     hdr_rtr,
    input  logic                     hdr_ext,
    input  logic [LEN_W-1:0]         hdr_len,
    input  logic                     byte_wr,
    input  logic [LEN_W-1:0]         byte_idx,
    input  logic [BYTE_W-1:0]        byte_val,
    input  logic                     frame_done,
    input  logic                     ovr_replace,
    input  logic [NUM_FLT-1:0]       flt_enable,
    input  logic [NUM_FLT*KEY_W-1:0] flt_value,
    input  logic [NUM_FLT*KEY_W-1:0] flt_mask,
    input  logic                     pop,
    output logic [OCC_W-1:0]         q_count,
    output logic                     q_full,
    output logic                     q_empty,
    output logic                     q_overrun,
    output logic [WORD_W-1:0]        head_lo,
    output logic [WORD_W-1:0]        head_hi,
    output logic [ID_W-1:0]          head_id,
    output logic [LEN_W-1:0]         head_len,
    output logic                     head_rtr,
    output logic                     head_ext,
    output logic [HIT_W-1:0]         head_hit,
    output logic                     pop_ack
);
    frame_t            cur_frame, head_frame;
    logic [KEY_W-1:0]  cur_key;
    logic              hit_any;
    logic [HIT_W-1:0]  hit_idx;

    can_rxf_assembler u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_strobe (hdr_strobe),
        .hdr_id     (hdr_id),
        .hdr_rtr    (hdr_rtr),
        .hdr_ext    (hdr_ext),
        .hdr_len    (hdr_len),
        .byte_wr    (byte_wr),
        .byte_idx   (byte_idx),
        .byte_val   (byte_val),
        .frame_o    (cur_frame),
        .key_o      (cur_key)
    );

    can_rxf_filter_bank #(.NUM_FLT(NUM_FLT), .HIT_W(HIT_W)) u_flt (
        .key_i     (cur_key),
        .enable_i  (flt_enable),
        .values_i  (flt_value),
        .masks_i   (flt_mask),
        .hit_any_o (hit_any),
        .hit_idx_o (hit_idx)
    );

    can_rxf_queue #(.DEPTH(DEPTH), .HIT_W(HIT_W), .OCC_W(OCC_W)) u_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (frame_done && hit_any),
        .push_frame (cur_frame),
        .push_hit   (hit_idx),
        .pop        (pop),
        .replace_en (ovr_replace),
        .head_frame (head_frame),
        .head_hit   (head_hit),
        .count      (q_count),
        .full       (q_full),
        .empty      (q_empty),
        .overrun    (q_overrun),
        .pop_ack    (pop_ack)
    );

    assign head_lo  = head_frame.data[WORD_W-1:0];
    assign head_hi  = head_frame.data[DATA_W-1:WORD_W];
    assign head_id  = head_frame.id;
    assign head_len = head_frame.len;
    assign head_rtr = head_frame.rtr;
    assign head_ext = head_frame.ext;

    // R3
    hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && hit_any) |-> flt_enable[hit_idx]);

    // R2
    drop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !hit_any && !(pop && !q_empty)) |=> $stable(q_count));
endmodule

// File: tb/can_rx_filter_fifo_tb_top.sv
module can_rx_filter_fifo_tb_top;
    localparam int NF = 20;
    localparam int DEPTH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hdr_strobe = 0, hdr_rtr = 0, hdr_ext = 0, byte_wr = 0, frame_done = 0;
    logic ovr_replace = 1, pop = 0;
    logic [28:0] hdr_id = '0;
    logic [3:0]  hdr_len = '0, byte_idx = '0;
    logic [7:0]  byte_val = '0;
    logic [NF-1:0] flt_enable = '0;
    logic [NF*31-1:0] flt_value = '0, flt_mask = '0;
    logic [3:0]  q_count;
    logic        q_full, q_empty, q_overrun, head_rtr, head_ext, pop_ack;
    logic [31:0] head_lo, head_hi;
    logic [28:0] head_id;
    logic [3:0]  head_len;
    logic [4:0]  head_hit;

    always #10 clk = ~clk;

    can_rx_filter_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .hdr_strobe(hdr_strobe), .hdr_id(hdr_id),
        .hdr_rtr(hdr_rtr), .hdr_ext(hdr_ext), .hdr_len(hdr_len), .byte_wr(byte_wr),
        .byte_idx(byte_idx), .byte_val(byte_val), .frame_done(frame_done),
        .ovr_replace(ovr_replace), .flt_enable(flt_enable), .flt_value(flt_value),
        .flt_mask(flt_mask), .pop(pop), .q_count(q_count), .q_full(q_full),
        .q_empty(q_empty), .q_overrun(q_overrun), .head_lo(head_lo), .head_hi(head_hi),
        .head_id(head_id), .head_len(head_len), .head_rtr(head_rtr), .head_ext(head_ext),
        .head_hit(head_hit), .pop_ack(pop_ack)
    );

    typedef struct {
        logic [28:0] id; logic rtr; logic ext; logic [3:0] len;
        logic [31:0] lo; logic [31:0] hi; logic [4:0] hit;
    } exp_t;

    exp_t sb[$];
    logic [30:0] bv [NF];
    logic [30:0] bm [NF];
    logic exp_ovr = 1'b0;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_hit(input logic [30:0] key);
        for (int i = 0; i < NF; i++)
            if (flt_enable[i] && (((key ^ bv[i]) & bm[i]) == '0)) return i;
        return -1;
    endfunction

    task automatic chk_status(input string tag);
        chk({tag, " count"}, q_count, sb.size());
        chk({tag, " empty"}, q_empty, sb.size() == 0);
        chk({tag, " full"}, q_full, sb.size() == DEPTH);
        chk({tag, " overrun"}, q_overrun, exp_ovr);
    endtask

    // Monitor side: compare the presented head with the scoreboard front.
    task automatic check_head(input string tag);
        if (sb.size() == 0) begin
            chk({tag, " R7 empty head"}, {head_lo, head_hi}, 64'h0);
            chk({tag, " R7 empty id"}, {head_id, head_len, head_rtr, head_ext, head_hit}, 0);
        end else begin
            chk({tag, " id"}, head_id, sb[0].id);
            chk({tag, " flags"}, {head_rtr, head_ext}, {sb[0].rtr, sb[0].ext});
            chk({tag, " len"}, head_len, sb[0].len);
            chk({tag, " R5 lo"}, head_lo, sb[0].lo);
            chk({tag, " R5 hi"}, head_hi, sb[0].hi);
            chk({tag, " R3 hit"}, head_hit, sb[0].hit);
        end
    endtask

    task automatic drain_one(input string tag);
        check_head(tag);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk({tag, " R8 ack"}, pop_ack, 1'b1);
        void'(sb.pop_front());
        exp_ovr = 1'b0;
        chk_status({tag, " R11"});
    endtask

    // Driver: build a frame, compute its fate, push expectation into the scoreboard.
    task automatic send_frame(input string tag, input logic [28:0] id, input logic rtr,
                              input logic ext, input logic [3:0] len, input logic [63:0] bytes,
                              input int nwr, input bit stray, input bit with_pop);
        exp_t e;
        int h;
        logic [63:0] d;
        bit popped;
        hdr_id = id; hdr_rtr = rtr; hdr_ext = ext; hdr_len = len; hdr_strobe = 1'b1;
        @(negedge clk);
        hdr_strobe = 1'b0;
        for (int k = 0; k < nwr; k++) begin
            byte_idx = 4'(k); byte_val = bytes[k*8 +: 8]; byte_wr = 1'b1;
            @(negedge clk);
            byte_wr = 1'b0;
        end
        if (stray) begin
            for (int k = 8; k < 16; k++) begin
                byte_idx = 4'(k); byte_val = 8'hEE; byte_wr = 1'b1;
                @(negedge clk);
                byte_wr = 1'b0;
            end
        end
        d = '0;
        for (int k = 0; k < 8; k++)
            if (k < nwr && k < int'(len)) d[k*8 +: 8] = bytes[k*8 +: 8];
        h = exp_hit({rtr, ext, id});
        e = '{id: id, rtr: rtr, ext: ext, len: len, lo: d[31:0], hi: d[63:32], hit: 5'(h)};
        popped = 0;
        if (with_pop && sb.size() > 0) begin
            check_head({tag, " pre-pop"});
            void'(sb.pop_front());
            exp_ovr = 1'b0;
            popped = 1;
        end
        if (h >= 0) begin
            if (sb.size() < DEPTH) sb.push_back(e);
            else begin
                if (ovr_replace) sb[sb.size()-1] = e;
                exp_ovr = 1'b1;
            end
        end
        frame_done = 1'b1; pop = with_pop;
        @(negedge clk);
        frame_done = 1'b0; pop = 1'b0;
        chk_status(tag);
        if (with_pop) chk({tag, " R8 ack"}, pop_ack, popped);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) begin bv[i] = '0; bm[i] = '0; end
        bv[0] = {2'b00, 11'h596, 18'h0};     bm[0] = {2'b00, 11'h7FF, 18'h0};
        bv[1] = {2'b00, 11'h014, 18'h0};     bm[1] = {2'b01, 11'h7FF, 18'h0};
        bv[2] = {2'b01, 11'h014, 18'h2C55D}; bm[2] = {2'b01, 11'h7FF, 18'h3FFFF};
        bv[3] = {2'b00, 11'h123, 18'h0};     bm[3] = {2'b00, 11'h7FF, 18'h0};
        bv[5] = {2'b10, 11'h000, 18'h0};     bm[5] = {2'b10, 11'h000, 18'h0};
        bv[7] = {2'b00, 11'h300, 18'h0};     bm[7] = {2'b00, 11'h7FF, 18'h0};
        for (int i = 0; i < NF; i++) begin
            flt_value[i*31 +: 31] = bv[i];
            flt_mask[i*31 +: 31]  = bm[i];
        end
        flt_enable = '0;
        flt_enable[0] = 1; flt_enable[1] = 1; flt_enable[2] = 1;
        flt_enable[5] = 1; flt_enable[7] = 1;  // filter 3 left disabled

        repeat (3) @(negedge clk);
        chk("R1 count", q_count, 0);
        chk("R1 empty", q_empty, 1);
        chk("R1 full/ovr/ack", {q_full, q_overrun, pop_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_head("R1");

        // Basic accept and read back
        send_frame("R2 accept", {11'h596, 18'h0}, 0, 0, 4'd2, 64'hADAC, 2, 0, 0);
        drain_one("R8 basic");

        // No enabled filter accepts (filter 3 disabled)
        send_frame("R2 drop", {11'h123, 18'h0}, 0, 0, 4'd2, 64'h11, 2, 0, 0);
        check_head("R2 drop");

        // Length masks upper lanes
        send_frame("R6 short", {11'h014, 18'h2C55D}, 0, 1, 4'd3, 64'h8877665544332211, 8, 0, 0);
        drain_one("R6 short");

        // Full length with stray indices 8..15
        send_frame("R5 stray", {11'h014, 18'h0}, 0, 0, 4'd8, 64'hF0E1D2C3B4A59687, 8, 1, 0);
        drain_one("R5 stray");

        // Fill, then replace-newest overrun
        ovr_replace = 1'b1;
        send_frame("R3 prio", {11'h596, 18'h0}, 1, 0, 4'd1, 64'h01, 1, 0, 0);
        send_frame("R7 fill2", {11'h300, 18'h0}, 1, 0, 4'd0, 64'h0, 0, 0, 0);
        send_frame("R7 fill3", {11'h300, 18'h0}, 0, 0, 4'd4, 64'hCAFEBABE, 4, 0, 0);
        send_frame("R9 replace", {11'h596, 18'h0}, 0, 0, 4'd1, 64'h5A, 1, 0, 0);
        drain_one("R11 clear");
        send_frame("R7 refill", {11'h014, 18'h0}, 0, 0, 4'd2, 64'h3344, 2, 0, 0);
        ovr_replace = 1'b0;
        send_frame("R10 discard", {11'h014, 18'h2C55D}, 0, 1, 4'd1, 64'h77, 1, 0, 0);
        drain_one("R10 order1");
        drain_one("R10 order2");
        drain_one("R10 order3");

        // Completion and pop in the same cycle on a full queue
        send_frame("R7 a", {11'h596, 18'h0}, 0, 0, 4'd2, 64'h0102, 2, 0, 0);
        send_frame("R7 b", {11'h014, 18'h0}, 0, 0, 4'd2, 64'h0304, 2, 0, 0);
        send_frame("R7 c", {11'h300, 18'h0}, 1, 0, 4'd2, 64'h0506, 2, 0, 0);
        send_frame("R11 simul", {11'h300, 18'h0}, 0, 0, 4'd2, 64'h0708, 2, 0, 1);
        drain_one("R11 s1");
        drain_one("R11 s2");
        drain_one("R11 s3");

        // Pop on an empty queue
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk("R8 empty pop ack", pop_ack, 0);
        chk_status("R8 empty pop");

        // Header clears lanes from the previous frame
        send_frame("R4 first", {11'h596, 18'h0}, 0, 0, 4'd8, 64'h1122334455667788, 8, 0, 0);
        send_frame("R4 second", {11'h596, 18'h0}, 0, 0, 4'd8, 64'h99, 1, 0, 0);
        drain_one("R4 d1");
        drain_one("R4 d2");
        check_head("R7 final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule